// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block is the digital controller placed in front of a 10-bit multichannel analog-to-digital converter. Software programs a single control word that sets the engine on, picks an operating mode and a reference, and names the channels to be sampled. Once the engine is on in normal mode, a warm-up phase counts a fixed number of sample strobes and then raises a ready flag. From that point, each strobe that finds the converter idle starts one conversion on the next enabled channel.

The converter itself is outside the block. The block drives a request pulse and a channel number. The converter answers later with a valid strobe and a 10-bit code, which the block stores in that channel's result slot. Results are read back over a word-addressed port, with two channels packed into each word. Channel 7 can be routed to the battery divider. The block raises a flag for that path while channel 7 is selected.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset the control word at offset 0x00, the trim word at 0xC4 and every result word read as zero, and convReq is low.
- R2: The control word keeps enable in bit 0, mode in bits 3:1, compensation force in bit 4, automatic compensation in bit 5, reference select in bits 7:6, channel-7 battery routing in bit 12, battery sense enable in bit 13 and channel enables in bits 31:16 (bit 16 + n enables channel n). All of these read back as written. Bit 8 is read-only and every other bit reads zero.
- R3: Offset 0xC4 holds a 4-bit trim value in bits 3:0, and its upper bits read zero.
- R4: Mode codes are 0 power-down, 1 standby and 7 normal. With enable set and mode 7, the ready flag in bit 8 rises after exactly INIT_TICKS sample strobes. No strobe raises it in any other mode, and the strobe that completes the warm-up issues no conversion.
- R5: When enable is cleared or the mode leaves 7, bit 8 clears and no further conversion requests are made. Re-entering normal mode repeats the full warm-up.
- R6: While ready, a sample strobe with the converter idle issues a one-cycle convReq in the following cycle. convSel then names the next enabled channel above the previous one, wrapping to the lowest enabled channel.
- R7: A convValid pulse stores convData into the selected channel at the clock edge where it is seen. Channel n appears in the word at 0x10 + 4*(n/2): even channels in bits 15:0 and odd channels in bits 31:16, each zero-extended from 10 bits.
- R8: Between a request and its convValid, sample strobes are ignored: no new request is made and convSel holds.
- R9: convBatt is high only while convSel is 7 and control bits 12 and 13 are both set.
- R10: Writes to the result words, writes with a non-zero low address pair and writes above 0xD0 change nothing. Reads of such offsets, and of any offset that is not mapped, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Byte offset for reads and writes |
| busWrEn | input | 1 | Write strobe for busWdata at busAddr |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| sampleTick | input | 1 | Sample strobe from the clock divider |
| convReq | output | 1 | One-cycle conversion start pulse |
| convSel | output | 4 | Channel being converted |
| convBatt | output | 1 | Battery divider route for channel 7 |
| convValid | input | 1 | Converter result strobe |
| convData | input | 10 | Converter result code |

## Verification
A wrong scan pointer shows as a convSel value that skips or repeats a channel, visible in the cycle that follows the strobe. A lost or stuck busy state shows as a second request before the answer, or as no request at all, in that same cycle. A warm-up counter that is off by one moves the rise of bit 8 by a whole strobe. A result written to the wrong slot shows on the next read of the packed words, one cycle after the valid pulse.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int MAX_CH   = 16;
  localparam int CH_IDX_W = 4;
  localparam int RES_W    = 10;
  localparam int ADDR_W   = 8;
  localparam int BAT_CH   = 7;

  localparam logic [ADDR_W-1:0] OFF_CTRL      = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DATA      = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_DATA_LAST = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_TRIM      = 8'hC4;
  localparam logic [ADDR_W-1:0] OFF_LAST      = 8'hD0;

  typedef enum logic [2:0] {
    MODE_OFF  = 3'd0,
    MODE_STBY = 3'd1,
    MODE_RUN  = 3'd7
  } opMode_e;

  typedef struct packed {
    logic                ready;
    logic                capture;
    logic [CH_IDX_W-1:0] chIdx;
  } scanStrb_t;
endpackage

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int INIT_TICKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlEn,
  input  logic [2:0]        ctrlMode,
  input  logic [MAX_CH-1:0] chEn,
  input  logic              sampleTick,
  input  logic              convValid,
  output logic              convReq,
  output scanStrb_t         strb
);
  localparam int CNT_W = $clog2(INIT_TICKS + 1);
  localparam logic [CH_IDX_W-1:0] LAST_CH = CH_IDX_W'(NUM_CH - 1);

  logic                run, ready, busy, anyEn;
  logic [CNT_W-1:0]    initCnt;
  logic [CH_IDX_W-1:0] curCh, nextCh;

  assign run   = ctrlEn && (ctrlMode == 3'(MODE_RUN));
  assign anyEn = |chEn;

  always_comb begin
    logic found;
    found  = 1'b0;
    nextCh = curCh;
    for (int i = 1; i <= NUM_CH; i++) begin
      int j;
      j = (int'(curCh) + i) % NUM_CH;
      if (!found && chEn[j]) begin
        nextCh = CH_IDX_W'(j);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCnt <= '0;
      ready   <= 1'b0;
      busy    <= 1'b0;
      convReq <= 1'b0;
      curCh   <= LAST_CH;
    end else if (!run) begin
      initCnt <= '0;
      ready   <= 1'b0;
      busy    <= 1'b0;
      convReq <= 1'b0;
      curCh   <= LAST_CH;
    end else begin
      convReq <= 1'b0;
      if (!ready) begin
        if (sampleTick) begin
          if (initCnt == CNT_W'(INIT_TICKS - 1)) ready <= 1'b1;
          else initCnt <= initCnt + 1'b1;
        end
      end else if (busy) begin
        if (convValid) busy <= 1'b0;
      end else if (sampleTick && anyEn) begin
        curCh   <= nextCh;
        busy    <= 1'b1;
        convReq <= 1'b1;
      end
    end
  end

  assign strb.ready   = ready;
  assign strb.capture = busy && convValid;
  assign strb.chIdx   = curCh;
endmodule

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [RES_W-1:0]  convData,
  input  scanStrb_t         strb,
  output logic              ctrlEn,
  output logic [2:0]        ctrlMode,
  output logic [MAX_CH-1:0] chEn,
  output logic              convBatt
);
  localparam logic [MAX_CH-1:0] CH_MASK = MAX_CH'((64'd1 << NUM_CH) - 64'd1);
  localparam bit HAS_BAT = NUM_CH > BAT_CH;

  logic       compForce, compAuto, batMode, batEn;
  logic [1:0] refSel;
  logic [3:0] trimVal;
  logic       addrOk, wrOk;
  logic [15:0] resPad [MAX_CH];

  assign addrOk = (busAddr[1:0] == 2'b00) && (busAddr <= OFF_LAST);
  assign wrOk   = busWrEn && addrOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn <= 1'b0; ctrlMode <= '0; compForce <= 1'b0; compAuto <= 1'b0;
      refSel <= '0; batMode <= 1'b0; batEn <= 1'b0; chEn <= '0; trimVal <= '0;
    end else if (wrOk) begin
      if (busAddr == OFF_CTRL) begin
        ctrlEn    <= busWdata[0];
        ctrlMode  <= busWdata[3:1];
        compForce <= busWdata[4];
        compAuto  <= busWdata[5];
        refSel    <= busWdata[7:6];
        batMode   <= busWdata[12];
        batEn     <= busWdata[13];
        chEn      <= busWdata[31:16] & CH_MASK;
      end else if (busAddr == OFF_TRIM) begin
        trimVal <= busWdata[3:0];
      end
    end
  end

  for (genvar g = 0; g < MAX_CH; g++) begin : gSlot
    if (g < NUM_CH) begin : gLive
      logic [RES_W-1:0] val;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) val <= '0;
        else if (strb.capture && strb.chIdx == CH_IDX_W'(g)) val <= convData;
      end
      assign resPad[g] = {{(16-RES_W){1'b0}}, val};
    end else begin : gNone
      assign resPad[g] = '0;
    end
  end

  always_comb begin
    logic [ADDR_W-1:0] off;
    off      = busAddr - OFF_DATA;
    busRdata = '0;
    if (addrOk) begin
      if (busAddr == OFF_CTRL)
        busRdata = {chEn, 2'b00, batEn, batMode, 3'b000, strb.ready,
                    refSel, compAuto, compForce, ctrlMode, ctrlEn};
      else if (busAddr == OFF_TRIM)
        busRdata = {28'd0, trimVal};
      else if (busAddr >= OFF_DATA && busAddr <= OFF_DATA_LAST)
        busRdata = {resPad[{off[4:2], 1'b1}], resPad[{off[4:2], 1'b0}]};
    end
  end

  assign convBatt = HAS_BAT && batEn && batMode && (strb.chIdx == CH_IDX_W'(BAT_CH));
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int INIT_TICKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        sampleTick,
  output logic        convReq,
  output logic [3:0]  convSel,
  output logic        convBatt,
  input  logic        convValid,
  input  logic [9:0]  convData
);
  logic              ctrlEn;
  logic [2:0]        ctrlMode;
  logic [MAX_CH-1:0] chEn;
  scanStrb_t         strb;

  adc_scan_fsm #(.NUM_CH(NUM_CH), .INIT_TICKS(INIT_TICKS)) u_fsm (
    .clk(clk), .rstN(rstN), .ctrlEn(ctrlEn), .ctrlMode(ctrlMode), .chEn(chEn),
    .sampleTick(sampleTick), .convValid(convValid), .convReq(convReq), .strb(strb)
  );

  adc_scan_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .convData(convData), .strb(strb),
    .ctrlEn(ctrlEn), .ctrlMode(ctrlMode), .chEn(chEn), .convBatt(convBatt)
  );

  assign convSel = strb.chIdx;
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk (
  input logic        clk,
  input logic        rstN,
  input logic        ctrlEn,
  input logic [2:0]  ctrlMode,
  input logic [15:0] chEn,
  input logic        ready,
  input logic        convReq,
  input logic [3:0]  convSel,
  input logic        convBatt
);
  AST_REQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> ready); // R6
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    convReq |=> !convReq); // R8
  AST_SEL_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> ((($past(chEn) >> convSel) & 16'd1) != 16'd0)); // R6
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrlEn && ctrlMode == 3'd7) |=> !ready); // R5
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> (convReq || !ready || $stable(convSel))); // R8
  AST_BATT_CH7: assert property (@(posedge clk) disable iff (!rstN)
    convBatt |-> convSel == 4'd7); // R9
endmodule

bind adc_scan_ctrl adc_scan_chk u_chk (
  .clk(clk), .rstN(rstN), .ctrlEn(ctrlEn), .ctrlMode(ctrlMode), .chEn(chEn),
  .ready(strb.ready), .convReq(convReq), .convSel(convSel), .convBatt(convBatt)
);

// File: tb/adc_scan_ctrl_test.sv
module adc_scan_ctrl_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sampleTick = 1'b0;
  logic        convReq;
  logic [3:0]  convSel;
  logic        convBatt;
  logic        convValid = 1'b0;
  logic [9:0]  convData = '0;
  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  adc_scan_ctrl #(.NUM_CH(16), .INIT_TICKS(4)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .sampleTick(sampleTick),
    .convReq(convReq), .convSel(convSel), .convBatt(convBatt),
    .convValid(convValid), .convData(convData)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic rdChk(string req, logic [7:0] a, logic [31:0] exp);
    busAddr = a; #1;
    check(req, busRdata, exp);
  endtask

  task automatic tick();
    @(negedge clk); sampleTick = 1'b1;
    @(negedge clk); sampleTick = 1'b0;
  endtask

  task automatic respond(logic [9:0] d);
    @(negedge clk); convValid = 1'b1; convData = d;
    @(negedge clk); convValid = 1'b0;
  endtask

  task automatic tickExpect(string req, logic [3:0] sel);
    tick();
    check(req, {31'd0, convReq}, 32'd1);
    check(req, {28'd0, convSel}, {28'd0, sel});
  endtask

  task automatic testReset();
    rdChk("R1", 8'h00, 32'h0);
    rdChk("R1", 8'hC4, 32'h0);
    rdChk("R1", 8'h10, 32'h0);
    rdChk("R1", 8'h2C, 32'h0);
    check("R1", {31'd0, convReq}, 32'd0);
  endtask

  task automatic testCtrlFields();
    wr(8'h00, 32'hFFFF_FFFF);
    rdChk("R2", 8'h00, 32'hFFFF_30FF);
    wr(8'h00, 32'h0000_0000);
    rdChk("R2", 8'h00, 32'h0);
  endtask

  task automatic testTrim();
    wr(8'hC4, 32'hFFFF_FFFF);
    rdChk("R3", 8'hC4, 32'h0000_000F);
    wr(8'hC4, 32'h0000_0005);
    rdChk("R3", 8'hC4, 32'h0000_0005);
  endtask

  task automatic testInit();
    wr(8'h00, 32'h0000_0003);
    for (int i = 0; i < 6; i++) begin
      tick();
      check("R4 standby no req", {31'd0, convReq}, 32'd0);
    end
    rdChk("R4 standby no ready", 8'h00, 32'h0000_0003);
    wr(8'h00, 32'h0026_000F);
    for (int i = 0; i < 3; i++) tick();
    rdChk("R4 not yet ready", 8'h00, 32'h0026_000F);
    tick();
    rdChk("R4 ready", 8'h00, 32'h0026_010F);
    check("R4 no req on last warmup tick", {31'd0, convReq}, 32'd0);
  endtask

  task automatic testScan();
    tickExpect("R6 first", 4'd1);
    respond(10'h3A5);
    rdChk("R7 ch1 high half", 8'h10, 32'h03A5_0000);
    tickExpect("R6 second", 4'd2);
    respond(10'h155);
    rdChk("R7 ch2 low half", 8'h14, 32'h0000_0155);
    tickExpect("R6 third", 4'd5);
    respond(10'h2AA);
    rdChk("R7 ch5 high half", 8'h18, 32'h02AA_0000);
    tickExpect("R6 wrap", 4'd1);
    check("R9 no batt", {31'd0, convBatt}, 32'd0);
    respond(10'h001);
    rdChk("R7 ch1 overwrite", 8'h10, 32'h0001_0000);
  endtask

  task automatic testBusy();
    tickExpect("R8 start", 4'd2);
    tick();
    check("R8 no req while busy", {31'd0, convReq}, 32'd0);
    check("R8 sel held", {28'd0, convSel}, 32'd2);
    respond(10'h3FF);
    rdChk("R7 ch2 full scale", 8'h14, 32'h0000_03FF);
    tickExpect("R8 resumes", 4'd5);
    respond(10'h123);
    rdChk("R7 ch5", 8'h18, 32'h0123_0000);
  endtask

  task automatic testIgnored();
    wr(8'h10, 32'hFFFF_FFFF);
    rdChk("R10 data write ignored", 8'h10, 32'h0001_0000);
    wr(8'h01, 32'h0000_0000);
    rdChk("R10 misaligned write", 8'h00, 32'h0026_010F);
    wr(8'hC5, 32'h0000_0000);
    rdChk("R10 misaligned trim", 8'hC4, 32'h0000_0005);
    wr(8'hD4, 32'hFFFF_FFFF);
    rdChk("R10 beyond range read", 8'hD4, 32'h0);
    rdChk("R10 misaligned read", 8'h02, 32'h0);
    rdChk("R10 unmapped read", 8'h40, 32'h0);
  endtask

  task automatic testBattery();
    wr(8'h00, 32'h0080_300F);
    tickExpect("R9 batt pick", 4'd7);
    check("R9 batt on", {31'd0, convBatt}, 32'd1);
    respond(10'h200);
    rdChk("R7 ch7", 8'h1C, 32'h0200_0000);
    wr(8'h00, 32'h0080_100F);
    tickExpect("R9 only mode bit", 4'd7);
    check("R9 batt off", {31'd0, convBatt}, 32'd0);
    respond(10'h0AA);
  endtask

  task automatic testLeave();
    wr(8'h00, 32'h0080_0003);
    rdChk("R5 ready cleared", 8'h00, 32'h0080_0003);
    tick();
    check("R5 no req", {31'd0, convReq}, 32'd0);
    wr(8'h00, 32'h0080_000E);
    tick();
    check("R5 disabled no req", {31'd0, convReq}, 32'd0);
    wr(8'h00, 32'h0080_000F);
    for (int i = 0; i < 3; i++) tick();
    rdChk("R5 warmup repeats", 8'h00, 32'h0080_000F);
    tick();
    rdChk("R5 ready again", 8'h00, 32'h0080_010F);
    tickExpect("R5 scan restarts", 4'd7);
    respond(10'h011);
    rdChk("R7 ch7 new", 8'h1C, 32'h0011_0000);
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCtrlFields();
    testTrim();
    testInit();
    testScan();
    testBusy();
    testIgnored();
    testBattery();
    testLeave();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule